// File: doc/BRIEF.md
# Coefficient Pair Byte Packer

The packer turns a run of polynomials, each 256 coefficients of 12 bits, into a byte stream. Every pair of adjacent coefficients becomes three bytes. The even coefficient fills the first byte and the low nibble of the second. The odd coefficient fills the high nibble of the second byte and all of the third. Polynomials are emitted in index order starting at 0.

A rank input `k_i` splits the index space. Polynomials whose index is below `k_i` come from the public result storage. The rest come from the secret storage, at relative index `index - k_i`. Both stores have a single registered read port, so the packer never asks for both coefficients of a pair in the same cycle. It reads the even coefficient and then the odd one while the three bytes of the previous pair leave. After a short priming, this keeps the stream at one byte per cycle.

The consumer takes bytes over a valid/ready handshake. A one-cycle done pulse closes each run.

Top module: `coef_pair_packer`

## Requirements
- R1: The first byte of each pair equals bits 7:0 of the even coefficient.
- R2: The second byte of each pair is {odd[3:0], even[11:8]}: the odd coefficient's low nibble in bits 7:4 and the even coefficient's bits 11:8 in bits 3:0.
- R3: The third byte of each pair equals bits 11:4 of the odd coefficient.
- R4: Pair p of a polynomial is coefficients 2p and 2p+1. Pairs leave in ascending order. Polynomials leave in index order 0 to `npoly_i`-1, 384 bytes each.
- R5: A polynomial with index i below `k_i` is read from the public store at address i*256+c. A polynomial with index i at or above `k_i` is read from the secret store at address (i-`k_i`)*256+c.
- R6: At most one of the two read enables is high in any cycle. Read data is taken from the port one cycle after its enable.
- R7: Each coefficient is read exactly once. The even read of a pair is issued in an earlier cycle than its odd read, so a run issues exactly 256 reads per polynomial.
- R8: While `byte_valid_o` is high and `byte_ready_i` is low, the byte stays valid and unchanged in the next cycle, and no read is issued.
- R9: `done_o` is high for exactly one cycle, the cycle after the last byte is accepted, and `byte_valid_o` is low in that cycle.
- R10: `start_i` is ignored while a run is active, and a start with `npoly_i` equal to 0 is ignored.
- R11: After reset, `byte_valid_o`, `done_o` and both read enables are low.
- R12: With `byte_ready_i` held high, `byte_valid_o` stays high on every cycle from the first byte to the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (sampled when idle) |
| k_i | input | 3 | Rank; number of leading polynomials taken from public storage |
| npoly_i | input | 4 | Number of polynomials in the run |
| pub_rd_en_o | output | 1 | Public store read enable |
| pub_rd_addr_o | output | 10 | Public store coefficient address |
| pub_rd_data_i | input | 12 | Public store read data, one cycle after enable |
| sec_rd_en_o | output | 1 | Secret store read enable |
| sec_rd_addr_o | output | 11 | Secret store coefficient address |
| sec_rd_data_i | input | 12 | Secret store read data, one cycle after enable |
| byte_valid_o | output | 1 | Output byte valid |
| byte_data_o | output | 8 | Output byte |
| byte_ready_i | input | 1 | Consumer ready |
| done_o | output | 1 | One-cycle pulse after the last byte |

## Verification
The bench uses the defaults of 256 coefficients and a maximum rank of 4. This gives a 1024-entry public store and a 2048-entry secret store, both filled with random 12-bit values. It runs rank 4 with a single public polynomial, and rank 2 with a half-and-half split. It also runs rank 1 with eight polynomials, which drives the secret relative index up to 6. Rank 3 with six polynomials runs under random backpressure. Alternating ready exercises the bypass case where the odd coefficient is consumed in the same cycle its read data returns.

// File: rtl/cpk_pkg.sv
`timescale 1ns/1ps
package cpk_pkg;
  localparam int COEF_W = 12;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_P0,    // even read of first pair
    ST_P1,    // odd read of first pair
    ST_P2,    // first pair lands
    ST_RUN
  } cpk_state_e;
endpackage

// File: rtl/cpk_pair_seq.sv
`timescale 1ns/1ps
module cpk_pair_seq #(
  parameter int PAIRS  = 128,
  parameter int PIDX_W = 3,
  parameter int NPW    = 4,
  localparam int PAIR_W = $clog2(PAIRS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [NPW-1:0]    npoly_i,
  output logic [PIDX_W-1:0] poly_o,
  output logic [PAIR_W-1:0] pair_o,
  output logic              last_o
);
  logic [PIDX_W-1:0] poly_q;
  logic [PAIR_W-1:0] pair_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poly_q <= '0;
      pair_q <= '0;
    end else if (load_i) begin
      poly_q <= '0;
      pair_q <= '0;
    end else if (adv_i) begin
      if (pair_q == PAIR_W'(PAIRS-1)) begin
        pair_q <= '0;
        poly_q <= poly_q + PIDX_W'(1);
      end else begin
        pair_q <= pair_q + PAIR_W'(1);
      end
    end
  end

  assign poly_o = poly_q;
  assign pair_o = pair_q;
  assign last_o = (pair_q == PAIR_W'(PAIRS-1)) &&
                  ((NPW'(poly_q) + NPW'(1)) == npoly_i);
endmodule

// File: rtl/cpk_src_sel.sv
`timescale 1ns/1ps
module cpk_src_sel #(
  parameter int N_COEF = 256,
  parameter int PIDX_W = 3,
  parameter int KW     = 3,
  parameter int CIDX_W = 8,
  parameter int PUB_AW = 10,
  parameter int SEC_AW = 11
) (
  input  logic [PIDX_W-1:0] poly_i,
  input  logic [KW-1:0]     k_i,
  input  logic [CIDX_W-1:0] coef_i,
  output logic              sec_o,
  output logic [PUB_AW-1:0] pub_addr_o,
  output logic [SEC_AW-1:0] sec_addr_o
);
  int pi, ki, ci;

  always_comb begin
    pi = int'(poly_i);
    ki = int'(k_i);
    ci = int'(coef_i);
    sec_o      = (pi >= ki);
    pub_addr_o = PUB_AW'(pi * N_COEF + ci);
    // relative slot inside secret storage; unused when sec_o is low
    sec_addr_o = SEC_AW'((pi - ki) * N_COEF + ci);
  end
endmodule

// File: rtl/cpk_byte_fmt.sv
`timescale 1ns/1ps
module cpk_byte_fmt
  import cpk_pkg::*;
(
  input  logic [1:0]        ph_i,
  input  logic [COEF_W-1:0] ev_i,
  input  logic [COEF_W-1:0] od_i,
  output logic [BYTE_W-1:0] byte_o
);
  always_comb begin
    unique case (ph_i)
      2'd0:    byte_o = ev_i[7:0];
      2'd1:    byte_o = {od_i[3:0], ev_i[11:8]};
      default: byte_o = od_i[11:4];
    endcase
  end
endmodule

// File: rtl/coef_pair_packer.sv
`timescale 1ns/1ps
module coef_pair_packer
  import cpk_pkg::*;
#(
  parameter int N_COEF = 256,
  parameter int K_MAX  = 4,
  localparam int PAIRS    = N_COEF / 2,
  localparam int PAIR_W   = $clog2(PAIRS),
  localparam int POLY_MAX = 2 * K_MAX,
  localparam int PIDX_W   = $clog2(POLY_MAX),
  localparam int KW       = $clog2(K_MAX + 1),
  localparam int NPW      = $clog2(POLY_MAX + 1),
  localparam int CIDX_W   = $clog2(N_COEF),
  localparam int PUB_AW   = $clog2(K_MAX * N_COEF),
  localparam int SEC_AW   = $clog2(POLY_MAX * N_COEF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [KW-1:0]     k_i,
  input  logic [NPW-1:0]    npoly_i,
  output logic              pub_rd_en_o,
  output logic [PUB_AW-1:0] pub_rd_addr_o,
  input  logic [COEF_W-1:0] pub_rd_data_i,
  output logic              sec_rd_en_o,
  output logic [SEC_AW-1:0] sec_rd_addr_o,
  input  logic [COEF_W-1:0] sec_rd_data_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o,
  input  logic              byte_ready_i,
  output logic              done_o
);
  cpk_state_e        state_q;
  logic [KW-1:0]     k_q;
  logic [NPW-1:0]    np_q;
  logic [1:0]        ph_q;
  logic              rd_more_q;
  logic              ev_pend_q, od_pend_q, sec_q, done_q;
  logic [COEF_W-1:0] cur_ev_q, cur_od_q, nxt_ev_q, nxt_od_q;

  logic              start_ok, hs, issue_ev, issue_od, issue, out_adv;
  logic [PIDX_W-1:0] rd_poly, out_poly;
  logic [PAIR_W-1:0] rd_pair, out_pair;
  logic              rd_last, out_last, src_sec;
  logic [CIDX_W-1:0] rd_coef;
  logic [PUB_AW-1:0] pub_addr;
  logic [SEC_AW-1:0] sec_addr;
  logic [COEF_W-1:0] rd_data;

  assign start_ok = (state_q == ST_IDLE) && start_i && (npoly_i != '0);
  assign hs       = byte_valid_o && byte_ready_i;
  assign out_adv  = hs && (ph_q == 2'd2);

  // even read on byte 0 accept, odd read on byte 1 accept: never both
  assign issue_ev = (state_q == ST_P0) ||
                    ((state_q == ST_RUN) && hs && (ph_q == 2'd0) && rd_more_q);
  assign issue_od = (state_q == ST_P1) ||
                    ((state_q == ST_RUN) && hs && (ph_q == 2'd1) && rd_more_q);
  assign issue    = issue_ev || issue_od;
  assign rd_coef  = CIDX_W'(2 * int'(rd_pair) + int'(issue_od));

  cpk_pair_seq #(.PAIRS(PAIRS), .PIDX_W(PIDX_W), .NPW(NPW)) u_rd_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_ok),
    .adv_i   (issue_od),
    .npoly_i (np_q),
    .poly_o  (rd_poly),
    .pair_o  (rd_pair),
    .last_o  (rd_last)
  );

  cpk_pair_seq #(.PAIRS(PAIRS), .PIDX_W(PIDX_W), .NPW(NPW)) u_out_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_ok),
    .adv_i   (out_adv),
    .npoly_i (np_q),
    .poly_o  (out_poly),
    .pair_o  (out_pair),
    .last_o  (out_last)
  );

  cpk_src_sel #(
    .N_COEF(N_COEF), .PIDX_W(PIDX_W), .KW(KW), .CIDX_W(CIDX_W),
    .PUB_AW(PUB_AW), .SEC_AW(SEC_AW)
  ) u_src (
    .poly_i     (rd_poly),
    .k_i        (k_q),
    .coef_i     (rd_coef),
    .sec_o      (src_sec),
    .pub_addr_o (pub_addr),
    .sec_addr_o (sec_addr)
  );

  assign pub_rd_en_o   = issue && !src_sec;
  assign sec_rd_en_o   = issue && src_sec;
  assign pub_rd_addr_o = pub_addr;
  assign sec_rd_addr_o = sec_addr;
  assign rd_data       = sec_q ? sec_rd_data_i : pub_rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      k_q       <= '0;
      np_q      <= '0;
      ph_q      <= '0;
      rd_more_q <= 1'b0;
      ev_pend_q <= 1'b0;
      od_pend_q <= 1'b0;
      sec_q     <= 1'b0;
      done_q    <= 1'b0;
      cur_ev_q  <= '0;
      cur_od_q  <= '0;
      nxt_ev_q  <= '0;
      nxt_od_q  <= '0;
    end else begin
      done_q    <= 1'b0;
      ev_pend_q <= issue_ev;
      od_pend_q <= issue_od;
      if (issue) sec_q <= src_sec;
      if (ev_pend_q) nxt_ev_q <= rd_data;
      if (od_pend_q) nxt_od_q <= rd_data;
      if (issue_od && rd_last) rd_more_q <= 1'b0;

      unique case (state_q)
        ST_IDLE: if (start_ok) begin
          k_q       <= k_i;
          np_q      <= npoly_i;
          rd_more_q <= 1'b1;
          state_q   <= ST_P0;
        end
        ST_P0: state_q <= ST_P1;
        ST_P1: state_q <= ST_P2;
        ST_P2: begin
          cur_ev_q <= nxt_ev_q;
          cur_od_q <= rd_data;
          ph_q     <= 2'd0;
          state_q  <= ST_RUN;
        end
        ST_RUN: if (hs) begin
          if (ph_q == 2'd2) begin
            ph_q <= 2'd0;
            if (out_last) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              cur_ev_q <= nxt_ev_q;
              // odd data may land in the same cycle as the last byte
              cur_od_q <= od_pend_q ? rd_data : nxt_od_q;
            end
          end else begin
            ph_q <= ph_q + 2'd1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  cpk_byte_fmt u_fmt (
    .ph_i   (ph_q),
    .ev_i   (cur_ev_q),
    .od_i   (cur_od_q),
    .byte_o (byte_data_o)
  );

  assign byte_valid_o = (state_q == ST_RUN);
  assign done_o       = done_q;

  logic unused_out;
  assign unused_out = ^{out_poly, out_pair};
endmodule

// File: rtl/coef_pair_packer_chk.sv
`timescale 1ns/1ps
module coef_pair_packer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pub_rd_en_o,
  input logic       sec_rd_en_o,
  input logic       byte_valid_o,
  input logic       byte_ready_i,
  input logic [7:0] byte_data_o,
  input logic       done_o
);
  a_r6_one_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pub_rd_en_o && sec_rd_en_o));

  a_r8_hold_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_data_o)));

  a_r8_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !byte_ready_i) |-> !(pub_rd_en_o || sec_rd_en_o));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !byte_valid_o);
endmodule

bind coef_pair_packer coef_pair_packer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pub_rd_en_o  (pub_rd_en_o),
  .sec_rd_en_o  (sec_rd_en_o),
  .byte_valid_o (byte_valid_o),
  .byte_ready_i (byte_ready_i),
  .byte_data_o  (byte_data_o),
  .done_o       (done_o)
);

// File: tb/coef_pair_packer_tb_top.sv
`timescale 1ns/1ps
module coef_pair_packer_tb_top;
  localparam int N     = 256;
  localparam int KM    = 4;
  localparam int PM    = 2 * KM;
  localparam int PUB_D = KM * N;
  localparam int SEC_D = PM * N;
  localparam int BPP   = 3 * N / 2;
  localparam int LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  k_in = '0;
  logic [3:0]  np_in = '0;
  logic        pub_en, sec_en;
  logic [9:0]  pub_addr;
  logic [10:0] sec_addr;
  logic [11:0] pub_q = '0, sec_q = '0;
  logic        bvalid, bready = 1'b0, done;
  logic [7:0]  bdata;

  always #2.5 clk = ~clk;

  coef_pair_packer #(.N_COEF(N), .K_MAX(KM)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .k_i(k_in), .npoly_i(np_in),
    .pub_rd_en_o(pub_en), .pub_rd_addr_o(pub_addr), .pub_rd_data_i(pub_q),
    .sec_rd_en_o(sec_en), .sec_rd_addr_o(sec_addr), .sec_rd_data_i(sec_q),
    .byte_valid_o(bvalid), .byte_data_o(bdata), .byte_ready_i(bready),
    .done_o(done)
  );

  logic [11:0] pub_mem [0:PUB_D-1];
  logic [11:0] sec_mem [0:SEC_D-1];
  logic [7:0]  ref_b   [0:PM*BPP-1];

  always_ff @(posedge clk) begin
    if (pub_en) pub_q <= pub_mem[pub_addr];
    if (sec_en) sec_q <= sec_mem[sec_addr];
  end

  int pub_cnt = 0, sec_cnt = 0, both_cnt = 0, par_bad = 0;
  logic exp_par = 1'b0;
  always @(posedge clk) begin
    if (pub_en) pub_cnt <= pub_cnt + 1;
    if (sec_en) sec_cnt <= sec_cnt + 1;
    if (pub_en && sec_en) both_cnt <= both_cnt + 1;
    if (pub_en || sec_en) begin
      if ((pub_en ? pub_addr[0] : sec_addr[0]) != exp_par) par_bad <= par_bad + 1;
      exp_par <= ~exp_par;
    end
  end

  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build_ref(input int k, input int np);
    for (int i = 0; i < np; i++) begin
      for (int p = 0; p < N / 2; p++) begin
        logic [11:0] ev, od;
        ev = (i < k) ? pub_mem[i*N + 2*p]     : sec_mem[(i-k)*N + 2*p];
        od = (i < k) ? pub_mem[i*N + 2*p + 1] : sec_mem[(i-k)*N + 2*p + 1];
        ref_b[i*BPP + 3*p]     = ev[7:0];
        ref_b[i*BPP + 3*p + 1] = {od[3:0], ev[11:8]};
        ref_b[i*BPP + 3*p + 2] = od[11:4];
      end
    end
  endtask

  // mode 0: ready high, 1: random, 2: alternating
  task automatic run_stream(input int k, input int np, input int mode, input bit poke);
    int total, idx, cyc, bubbles, p0, s0, b0, par0;
    bit prev_stall, seen, rdy;
    logic [7:0] prev_data;
    build_ref(k, np);
    total = np * BPP; idx = 0; cyc = 0; bubbles = 0;
    prev_stall = 0; seen = 0; prev_data = '0;
    p0 = pub_cnt; s0 = sec_cnt; b0 = both_cnt; par0 = par_bad;
    @(negedge clk);
    start = 1'b1; k_in = 3'(k); np_in = 4'(np);
    @(negedge clk);
    start = 1'b0;
    while (idx < total && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      if (prev_stall)
        chk(bvalid && bdata == prev_data, "R8 hold under stall", int'(bdata), int'(prev_data));
      if (mode == 0 && seen && !bvalid) bubbles++;
      if (poke && idx >= 60 && idx < 66) begin
        start = 1'b1; np_in = 4'd1; k_in = 3'd0;
      end else start = 1'b0;
      case (mode)
        0: rdy = 1'b1;
        1: rdy = (($urandom % 10) < 7);
        default: rdy = cyc[0];
      endcase
      bready = rdy;
      if (bvalid) begin
        seen = 1;
        if (rdy) begin
          case (idx % 3)
            0: chk(bdata == ref_b[idx], "R1/R4 byte0", int'(bdata), int'(ref_b[idx]));
            1: chk(bdata == ref_b[idx], "R2/R4 byte1", int'(bdata), int'(ref_b[idx]));
            default: chk(bdata == ref_b[idx], "R3/R4 byte2", int'(bdata), int'(ref_b[idx]));
          endcase
          idx++;
        end
      end
      prev_stall = bvalid && !rdy;
      prev_data  = bdata;
    end
    start = 1'b0;
    chk(idx == total, "R4 byte count", idx, total);
    if (mode == 0) chk(bubbles == 0, "R12 no bubbles", bubbles, 0);
    @(negedge clk);
    bready = 1'b0;
    chk(done == 1'b1 && bvalid == 1'b0, "R9 done after last", int'({done, bvalid}), 2);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
    repeat (6) @(negedge clk);
    chk(bvalid == 1'b0, "R10 no restart", int'(bvalid), 0);
    chk(pub_cnt - p0 == ((np < k) ? np : k) * N, "R5 public reads", pub_cnt - p0,
        ((np < k) ? np : k) * N);
    chk(sec_cnt - s0 == ((np > k) ? np - k : 0) * N, "R5 secret reads", sec_cnt - s0,
        ((np > k) ? np - k : 0) * N);
    chk(both_cnt == b0, "R6 one port per cycle", both_cnt - b0, 0);
    chk(par_bad == par0, "R7 even before odd", par_bad - par0, 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(!bvalid && !done && !pub_en && !sec_en, "R11 in reset",
        int'({bvalid, done, pub_en, sec_en}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bvalid && !done && !pub_en && !sec_en, "R11 after reset",
        int'({bvalid, done, pub_en, sec_en}), 0);
  endtask

  task automatic test_zero_start();
    int p0, s0, seenv;
    p0 = pub_cnt; s0 = sec_cnt; seenv = 0;
    @(negedge clk);
    start = 1'b1; np_in = 4'd0; k_in = 3'd2;
    @(negedge clk);
    start = 1'b0;
    repeat (8) begin
      @(negedge clk);
      if (bvalid || done) seenv++;
    end
    chk(seenv == 0, "R10 zero-count start ignored", seenv, 0);
    chk(pub_cnt == p0 && sec_cnt == s0, "R10 zero-count no reads",
        (pub_cnt - p0) + (sec_cnt - s0), 0);
  endtask

  initial begin
    #950000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < PUB_D; i++) pub_mem[i] = 12'($urandom);
    for (int i = 0; i < SEC_D; i++) sec_mem[i] = 12'($urandom);
    repeat (4) @(negedge clk);
    test_reset();
    run_stream(2, 4, 0, 1'b0);   // split public/secret, full rate
    run_stream(4, 1, 0, 1'b0);   // single public polynomial
    run_stream(3, 6, 1, 1'b0);   // random backpressure
    run_stream(1, 8, 2, 1'b0);   // deep secret index, alternating ready
    run_stream(2, 3, 0, 1'b1);   // start pulses while active
    test_zero_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule